// File: doc/BRIEF.md
# Ripple FIFO of Single-Entry Cells

This block is a bounded first-in first-out queue made of a straight chain of N one-word cells. Each cell holds a single data word and a full flag. A new word always enters the first cell and then moves toward the last cell by one position per clock. A cell hands its word on only when the next cell is empty, or when the next cell is passing its own word on in the same clock. The consumer reads the oldest word from the last cell with a read strobe.

Each write attempt gets a result in the same cycle. The `wr_ok` pulse means the word was accepted. The `wr_alarm` pulse means it was refused because every cell was occupied. A refused word is discarded. The two pulses let the surrounding logic count missed writes or stall the producer. Two status outputs show the occupancy of the ends of the chain: `in_ready` for the entry cell and `out_valid` for the exit cell. The whole block runs on one clock. The word width and the number of cells are parameters.

Top module: `ripple_fifo`

## Requirements
- R1: After synchronous reset every cell is empty and holds zero, so `out_valid` is 0, `in_ready` is 1 and `rd_data` is all zeros.
- R2: A write attempt (`wr_valid` high at a rising edge) is accepted if and only if at least one of the N cells was empty before that edge. An accepted word enters the chain at that edge.
- R3: `wr_ok` and `wr_alarm` are valid in the same cycle as the attempt. While `wr_valid` is high, exactly one of them is high. `wr_alarm` is high only when all N full flags are set. With `wr_valid` low, both are 0.
- R4: Words leave in the order they were accepted. While `out_valid` is 1, `rd_data` carries the oldest word held.
- R5: When a write into an empty chain is captured at edge k, `out_valid` stays 0 through edge k+N-2 and is 1 after edge k+N-1.
- R6: `rd_req` at an edge with `out_valid` 1 removes the oldest word. `rd_req` while `out_valid` is 0 has no effect. Without `rd_req`, `out_valid` and `rd_data` hold their values.
- R7: A refused write leaves every stored word unchanged, and the refused word never appears at the output.
- R8: `in_ready` is 1 exactly when the first cell is empty. `out_valid` is 1 exactly when the last cell is full. After a word is captured into an empty first cell, `in_ready` is 0 in the next cycle. It returns to 1 once the word has moved to the second cell.
- R9: With no reads, the chain holds exactly N words: the first N attempts are accepted and the following ones raise `wr_alarm`.
- R10: When all cells are full, a write and a read in the same cycle give `wr_alarm`. The read still removes the oldest word at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Write attempt strobe |
| wr_data | input | WIDTH | Word offered with the attempt |
| rd_req | input | 1 | Read strobe; removes the oldest word when `out_valid` is 1 |
| rd_data | output | WIDTH | Word stored in the last cell |
| out_valid | output | 1 | Last cell holds a word |
| in_ready | output | 1 | First cell is empty |
| wr_ok | output | 1 | Write attempt accepted this cycle |
| wr_alarm | output | 1 | Write attempt refused this cycle, all cells full |

## Verification
`wr_ok` and `wr_alarm` are combinational, so the bench compares them in the cycle of the attempt, 1 ns after it drives the inputs and before the capturing edge. `in_ready`, `out_valid` and `rd_data` change only at edges. The bench samples them 1 ns after the edge that causes each change: one edge after a capture for `in_ready`, N-1 edges after the capturing edge for the first arrival at the output, and one edge after a pop. A reference queue in the bench predicts acceptance from its own word count. It also gives the exact order in which words must appear.

// File: rtl/rfifo_pkg.sv
package rfifo_pkg;

    // Result of one write attempt, as seen at the block edge.
    typedef enum logic [1:0] {
        ATT_NONE    = 2'b00,
        ATT_TAKEN   = 2'b01,
        ATT_REFUSED = 2'b10
    } attempt_e;

    // Per-cycle control of one cell.
    typedef struct packed {
        logic take_in;
        logic give_out;
        logic accept;
    } cell_ctl_t;

    // A middle cell can take a word when it is empty or when it is
    // passing its own word on in the same clock. The exit cell can take
    // a word only when it is empty.
    function automatic logic cell_accept(input logic full,
                                         input logic dn_accept,
                                         input logic is_last);
        return !full || (!is_last && dn_accept);
    endfunction

    function automatic attempt_e judge_attempt(input logic attempt,
                                               input logic no_room);
        if (!attempt)
            return ATT_NONE;
        else if (no_room)
            return ATT_REFUSED;
        else
            return ATT_TAKEN;
    endfunction

endpackage

// File: rtl/rfifo_cell.sv
module rfifo_cell
    import rfifo_pkg::*;
#(
    parameter int WIDTH   = 8,
    parameter bit IS_LAST = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             up_valid,
    input  logic [WIDTH-1:0] up_word,
    input  logic             dn_accept,
    output logic             accept,
    output logic             full,
    output logic [WIDTH-1:0] word
);

    cell_ctl_t ctl;

    always_comb begin
        ctl.give_out = full && dn_accept;
        ctl.accept   = cell_accept(full, dn_accept, IS_LAST);
        ctl.take_in  = up_valid && ctl.accept;
    end

    assign accept = ctl.accept;

    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            word <= '0;
        end else begin
            full <= ctl.take_in || (full && !ctl.give_out);
            if (ctl.take_in)
                word <= up_word;
        end
    end

endmodule

// File: rtl/rfifo_chain.sv
module rfifo_chain
    import rfifo_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_valid,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_req,
    output logic             room,
    output logic [DEPTH-1:0] full_vec,
    output logic [WIDTH-1:0] tail_word
);

    localparam int LAST = DEPTH - 1;

    logic [DEPTH-1:0] acc_vec;
    logic [DEPTH-1:0] upv_vec;
    logic [DEPTH-1:0] dna_vec;
    logic [WIDTH-1:0] words [DEPTH];
    logic [WIDTH-1:0] upw   [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        if (g == 0) begin : g_head
            assign upv_vec[g] = wr_valid;
            assign upw[g]     = wr_data;
        end else begin : g_body
            assign upv_vec[g] = full_vec[g-1];
            assign upw[g]     = words[g-1];
        end

        if (g == LAST) begin : g_tail
            assign dna_vec[g] = rd_req;
        end else begin : g_link
            assign dna_vec[g] = acc_vec[g+1];
        end

        rfifo_cell #(
            .WIDTH  (WIDTH),
            .IS_LAST(g == LAST)
        ) u_cell (
            .clk      (clk),
            .rst      (rst),
            .up_valid (upv_vec[g]),
            .up_word  (upw[g]),
            .dn_accept(dna_vec[g]),
            .accept   (acc_vec[g]),
            .full     (full_vec[g]),
            .word     (words[g])
        );
    end

    assign room      = acc_vec[0];
    assign tail_word = words[LAST];

endmodule

// File: rtl/rfifo_report.sv
module rfifo_report
    import rfifo_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic             wr_valid,
    input  logic             room,
    input  logic [DEPTH-1:0] full_vec,
    output logic             wr_ok,
    output logic             wr_alarm
);

    attempt_e verdict;

    always_comb begin
        verdict  = judge_attempt(wr_valid, &full_vec);
        wr_alarm = (verdict == ATT_REFUSED);
        wr_ok    = wr_valid && room;
    end

endmodule

// File: rtl/ripple_fifo.sv
module ripple_fifo
    import rfifo_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_valid,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_req,
    output logic [WIDTH-1:0] rd_data,
    output logic             out_valid,
    output logic             in_ready,
    output logic             wr_ok,
    output logic             wr_alarm
);

    logic             room;
    logic [DEPTH-1:0] full_vec;

    rfifo_chain #(
        .WIDTH(WIDTH),
        .DEPTH(DEPTH)
    ) u_chain (
        .clk      (clk),
        .rst      (rst),
        .wr_valid (wr_valid),
        .wr_data  (wr_data),
        .rd_req   (rd_req),
        .room     (room),
        .full_vec (full_vec),
        .tail_word(rd_data)
    );

    rfifo_report #(
        .DEPTH(DEPTH)
    ) u_report (
        .wr_valid(wr_valid),
        .room    (room),
        .full_vec(full_vec),
        .wr_ok   (wr_ok),
        .wr_alarm(wr_alarm)
    );

    assign out_valid = full_vec[DEPTH-1];
    assign in_ready  = !full_vec[0];

endmodule

// File: rtl/rfifo_checker.sv
module rfifo_checker #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_valid,
    input logic             rd_req,
    input logic [WIDTH-1:0] rd_data,
    input logic             out_valid,
    input logic             in_ready,
    input logic             wr_ok,
    input logic             wr_alarm
);

    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0] occ;
    logic [CW-1:0] occ_next;

    always_comb begin
        occ_next = occ;
        if (wr_ok)
            occ_next = occ_next + CW'(1);
        if (rd_req && out_valid)
            occ_next = occ_next - CW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst)
            occ <= '0;
        else
            occ <= occ_next;
    end

    p_alarm_needs_attempt_r2: assert property (@(posedge clk) disable iff (rst)
        wr_alarm |-> wr_valid);

    p_attempt_resolves_r3: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> (wr_ok != wr_alarm));

    p_no_attempt_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        !wr_valid |-> !(wr_ok || wr_alarm));

    p_alarm_only_at_capacity_r9: assert property (@(posedge clk) disable iff (rst)
        wr_alarm |-> (occ == CW'(DEPTH)));

    p_capacity_alarms_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && occ == CW'(DEPTH)) |-> wr_alarm);

    p_empty_no_output_r6: assert property (@(posedge clk) disable iff (rst)
        (occ == '0) |-> !out_valid);

    p_head_holds_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !rd_req) |=> (out_valid && $stable(rd_data)));

    p_capture_blocks_entry_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_ok && in_ready) |=> !in_ready);

endmodule

bind ripple_fifo rfifo_checker #(
    .WIDTH(WIDTH),
    .DEPTH(DEPTH)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_valid (wr_valid),
    .rd_req   (rd_req),
    .rd_data  (rd_data),
    .out_valid(out_valid),
    .in_ready (in_ready),
    .wr_ok    (wr_ok),
    .wr_alarm (wr_alarm)
);

// File: tb/tb_ripple_fifo.sv
module tb_ripple_fifo;

    localparam int W = 8;
    localparam int D = 4;

    logic         clk = 1'b0;
    logic         rst;
    logic         wr_valid;
    logic [W-1:0] wr_data;
    logic         rd_req;
    logic [W-1:0] rd_data;
    logic         out_valid;
    logic         in_ready;
    logic         wr_ok;
    logic         wr_alarm;

    int total = 0;
    int bad   = 0;
    logic [W-1:0] q[$];

    always #5 clk = ~clk;

    ripple_fifo #(.WIDTH(W), .DEPTH(D)) dut (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
        .rd_req(rd_req), .rd_data(rd_data), .out_valid(out_valid),
        .in_ready(in_ready), .wr_ok(wr_ok), .wr_alarm(wr_alarm)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst = 1'b1; wr_valid = 1'b0; rd_req = 1'b0; wr_data = '0;
        q.delete();
        repeat (3) tick();
        rst = 1'b0;
    endtask

    task automatic drain(input string req);
        int guard = 0;
        while (q.size() > 0 && guard < 20 * D) begin
            if (out_valid) begin
                chk(req, "head word", int'(rd_data), int'(q[0]));
                rd_req = 1'b1;
                void'(q.pop_front());
            end else begin
                rd_req = 1'b0;
            end
            tick();
            guard++;
        end
        rd_req = 1'b0;
        chk(req, "words left after drain", q.size(), 0);
    endtask

    task automatic t_reset();
        do_reset();
        #1;
        chk("R1", "out_valid after reset", int'(out_valid), 0);
        chk("R1", "in_ready after reset", int'(in_ready), 1);
        chk("R1", "rd_data after reset", int'(rd_data), 0);
        chk("R3", "ok without attempt", int'(wr_ok), 0);
        chk("R3", "alarm without attempt", int'(wr_alarm), 0);
    endtask

    task automatic t_latency();
        int edges = 0;
        do_reset();
        wr_valid = 1'b1; wr_data = 8'hA5;
        #1;
        chk("R3", "ok on accepted write", int'(wr_ok), 1);
        chk("R3", "alarm on accepted write", int'(wr_alarm), 0);
        tick();
        wr_valid = 1'b0;
        chk("R8", "in_ready after capture", int'(in_ready), 0);
        while (!out_valid && edges < 3 * D) begin
            tick();
            edges++;
            if (edges == 1)
                chk("R8", "in_ready after move on", int'(in_ready), 1);
        end
        chk("R5", "edges to output", edges, D - 1);
        chk("R4", "word at output", int'(rd_data), 8'hA5);
        rd_req = 1'b1;
        tick();
        rd_req = 1'b0;
        chk("R6", "out_valid after pop", int'(out_valid), 0);
    endtask

    task automatic t_fill_overflow();
        do_reset();
        for (int n = 0; n < D + 2; n++) begin
            wr_valid = 1'b1;
            wr_data  = W'(8'h10 + n);
            #1;
            chk("R9", "ok while filling", int'(wr_ok), int'(n < D));
            chk("R2", "alarm while filling", int'(wr_alarm), int'(n >= D));
            if (n < D) q.push_back(wr_data);
            tick();
        end
        wr_valid = 1'b0;
        chk("R8", "in_ready when full", int'(in_ready), 0);
        chk("R8", "out_valid when full", int'(out_valid), 1);
        drain("R7");
        chk("R6", "out_valid after drain", int'(out_valid), 0);
    endtask

    task automatic t_empty_read();
        do_reset();
        rd_req = 1'b1;
        tick();
        tick();
        rd_req = 1'b0;
        chk("R6", "out_valid after empty read", int'(out_valid), 0);
        chk("R6", "in_ready after empty read", int'(in_ready), 1);
        wr_valid = 1'b1; wr_data = 8'h3C;
        q.push_back(wr_data);
        tick();
        wr_valid = 1'b0;
        drain("R6");
    endtask

    task automatic t_full_rw();
        do_reset();
        for (int n = 0; n < D; n++) begin
            wr_valid = 1'b1;
            wr_data  = W'(8'h40 + n);
            q.push_back(wr_data);
            tick();
        end
        wr_valid = 1'b0;
        repeat (D) tick();
        chk("R10", "out_valid before combined access", int'(out_valid), 1);
        wr_valid = 1'b1; wr_data = 8'hEE; rd_req = 1'b1;
        #1;
        chk("R10", "alarm on combined access", int'(wr_alarm), 1);
        chk("R10", "ok on combined access", int'(wr_ok), 0);
        chk("R10", "head on combined access", int'(rd_data), int'(q[0]));
        void'(q.pop_front());
        tick();
        wr_valid = 1'b0; rd_req = 1'b0;
        drain("R7");
        repeat (2 * D) tick();
        chk("R7", "refused word absent", int'(out_valid), 0);
    endtask

    task automatic t_stream();
        do_reset();
        for (int i = 0; i < 60; i++) begin
            logic wv, rr, exp_alarm, pop;
            wv = (i % 3) != 2;
            rr = (i % 3) == 0 || i > 45;
            wr_valid = wv;
            wr_data  = W'(8'h80 + i);
            rd_req   = rr;
            #1;
            exp_alarm = wv && (q.size() == D);
            chk("R2", "stream alarm", int'(wr_alarm), int'(exp_alarm));
            chk("R3", "stream ok", int'(wr_ok), int'(wv && !exp_alarm));
            pop = rr && out_valid;
            if (pop)
                chk("R4", "stream head", int'(rd_data), int'(q[0]));
            tick();
            if (pop) void'(q.pop_front());
            if (wv && !exp_alarm) q.push_back(W'(8'h80 + i));
        end
        wr_valid = 1'b0; rd_req = 1'b0;
        drain("R4");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_latency();
        t_fill_overflow();
        t_empty_read();
        t_full_rw();
        t_stream();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule